// File: doc/BRIEF.md
# UART interrupt status and mask logic

This block turns the occupancy of a UART's receive and transmit FIFOs into interrupt information. Every cycle it compares the two FIFO counts against programmable trigger levels and against the empty and full limits, and presents the result as a live status word. The same conditions, together with single-cycle pulses for receive overrun and receive timeout, are collected into a sticky interrupt word. A bit in the sticky word stays set until software writes a 1 to it.

Software selects the interrupt sources through a mask. The mask can only be changed through two write-only addresses: one that sets the bits written as 1 and one that clears them. The block drives a single level interrupt, which is high while any masked sticky bit is set. A small register bus with a combinational read port gives access to the mask, the sticky word, the live status and the two trigger levels.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (address 4) is purely combinational from the current counts: bit0 = RX count >= RX trigger, bit1 = RX count is 0, bit2 = RX count equals RX depth (64), bit3 = TX count is 0, bit4 = TX count equals TX depth (64), bit13 = TX count >= TX trigger. All other bits read 0.
- R2: The RX trigger level (address 5) and the TX trigger level (address 6) reset to 32. A bus write stores the low count bits of the written data. The stored level takes effect in the status compare from the next cycle.
- R3: On every clock edge, status bits 4:0 that are high are ORed into bits 4:0 of the sticky word (address 3), and status bit13 is ORed into sticky bit10.
- R4: A pulse on the RX overrun input sets sticky bit5, and a pulse on the receive timeout input sets sticky bit8, at the next clock edge.
- R5: Writing address 3 clears the sticky bits written as 1. If a set condition for a bit is present in the same cycle, the bit stays set.
- R6: Writing address 0 ORs the written data into the mask (readable at address 2).
- R7: Writing address 1 clears the mask bits written as 1.
- R8: A write to address 2 leaves the mask unchanged.
- R9: The interrupt output is high exactly when the mask and the sticky word share at least one set bit.
- R10: After reset the mask and the sticky word are zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | RX FIFO occupancy, 0 to RX depth |
| tx_count | input | 7 | TX FIFO occupancy, 0 to TX depth |
| ev_overrun | input | 1 | One-cycle RX overrun event |
| ev_timeout | input | 1 | One-cycle receive timeout event |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
The live status word has no register, so the bench reads it one time unit after it drives the counts, with no clock edge in between. Sticky bits, mask updates and trigger writes appear at the first rising edge after the stimulus is driven. The interrupt follows combinationally from those registers. The bench therefore drives each stimulus at a falling edge and removes it at the next falling edge, which lets exactly one rising edge see it. It then reads the result at a later falling edge. This keeps the set-while-clear case to a single capturing edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MSET   = 3'd0,
    A_MCLR   = 3'd1,
    A_MASK   = 3'd2,
    A_STICKY = 3'd3,
    A_STAT   = 3'd4,
    A_RXTRIG = 3'd5,
    A_TXTRIG = 3'd6
  } reg_addr_e;

  localparam int B_RX_TRIG    = 0;
  localparam int B_RX_EMPTY   = 1;
  localparam int B_RX_FULL    = 2;
  localparam int B_TX_EMPTY   = 3;
  localparam int B_TX_FULL    = 4;
  localparam int B_OVERRUN    = 5;
  localparam int B_TIMEOUT    = 8;
  localparam int B_TX_TRIG_IR = 10;
  localparam int B_TX_TRIG_ST = 13;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] trig,
  output logic          empty,
  output logic          full,
  output logic          at_trig
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == FULL_CNT);
    at_trig = (cnt >= trig);
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          en;

  always_comb begin
    en    = (|set_vec) | (|clr_vec);
    q_nxt = (q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          en;

  always_comb begin
    en    = set_we | clr_we;
    q_nxt = q;
    if (set_we) q_nxt = q | wdata;
    if (clr_we) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RX_DEPTH   = 64,
  parameter int TX_DEPTH   = 64,
  parameter int TRIG_RESET = 32,
  parameter int RXC_W      = $clog2(RX_DEPTH + 1),
  parameter int TXC_W      = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RXC_W-1:0]  rx_count,
  input  logic [TXC_W-1:0]  tx_count,
  input  logic              ev_overrun,
  input  logic              ev_timeout,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam logic [RXC_W-1:0] RX_TRIG_RST = RXC_W'(TRIG_RESET);
  localparam logic [TXC_W-1:0] TX_TRIG_RST = TXC_W'(TRIG_RESET);

  logic             wr_en;
  logic             we_mset, we_mclr, we_sticky, we_rxtrig, we_txtrig;
  logic [RXC_W-1:0] rx_trig_q;
  logic [TXC_W-1:0] tx_trig_q;
  logic             rx_empty, rx_full, rx_at_trig;
  logic             tx_empty, tx_full, tx_at_trig;
  logic [DW-1:0]    status_vec;
  logic [DW-1:0]    set_vec;
  logic [DW-1:0]    clr_vec;
  logic [DW-1:0]    sticky_q;
  logic [DW-1:0]    mask_q;

  // write strobes
  always_comb begin
    wr_en     = bus_sel & bus_wr;
    we_mset   = wr_en & (bus_addr == A_MSET);
    we_mclr   = wr_en & (bus_addr == A_MCLR);
    we_sticky = wr_en & (bus_addr == A_STICKY);
    we_rxtrig = wr_en & (bus_addr == A_RXTRIG);
    we_txtrig = wr_en & (bus_addr == A_TXTRIG);
  end

  // trigger levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_trig_q <= RX_TRIG_RST;
    else if (we_rxtrig) rx_trig_q <= bus_wdata[RXC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_trig_q <= TX_TRIG_RST;
    else if (we_txtrig) tx_trig_q <= bus_wdata[TXC_W-1:0];
  end

  uart_irq_flags #(.DEPTH(RX_DEPTH), .CW(RXC_W)) u_rx_flags (
    .cnt(rx_count), .trig(rx_trig_q),
    .empty(rx_empty), .full(rx_full), .at_trig(rx_at_trig)
  );

  uart_irq_flags #(.DEPTH(TX_DEPTH), .CW(TXC_W)) u_tx_flags (
    .cnt(tx_count), .trig(tx_trig_q),
    .empty(tx_empty), .full(tx_full), .at_trig(tx_at_trig)
  );

  // live status and sticky set/clear vectors
  always_comb begin
    status_vec               = '0;
    status_vec[B_RX_TRIG]    = rx_at_trig;
    status_vec[B_RX_EMPTY]   = rx_empty;
    status_vec[B_RX_FULL]    = rx_full;
    status_vec[B_TX_EMPTY]   = tx_empty;
    status_vec[B_TX_FULL]    = tx_full;
    status_vec[B_TX_TRIG_ST] = tx_at_trig;

    set_vec                  = '0;
    set_vec[4:0]             = status_vec[4:0];
    set_vec[B_TX_TRIG_IR]    = status_vec[B_TX_TRIG_ST];
    set_vec[B_OVERRUN]       = ev_overrun;
    set_vec[B_TIMEOUT]       = ev_timeout;

    clr_vec = we_sticky ? bus_wdata : '0;
  end

  uart_irq_sticky #(.DW(DW)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(sticky_q)
  );

  uart_irq_mask #(.DW(DW)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(we_mset), .clr_we(we_mclr),
    .wdata(bus_wdata), .q(mask_q)
  );

  // read port and interrupt
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK:   bus_rdata = mask_q;
      A_STICKY: bus_rdata = sticky_q;
      A_STAT:   bus_rdata = status_vec;
      A_RXTRIG: bus_rdata = DW'(rx_trig_q);
      A_TXTRIG: bus_rdata = DW'(tx_trig_q);
      default:  bus_rdata = '0;
    endcase
    irq = |(mask_q & sticky_q);
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              ev_overrun,
  input logic              ev_timeout,
  input logic              irq,
  input logic [DW-1:0]     status_vec,
  input logic [DW-1:0]     sticky_q,
  input logic [DW-1:0]     mask_q
);
  logic wr_any;
  assign wr_any = bus_sel & bus_wr;

  AST_TXTRIG_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    status_vec[B_TX_TRIG_ST] |=> sticky_q[B_TX_TRIG_IR]); // R3

  AST_OVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> sticky_q[B_OVERRUN]); // R4

  AST_TMO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> sticky_q[B_TIMEOUT]); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[B_OVERRUN] && !(wr_any && bus_addr == A_STICKY && bus_wdata[B_OVERRUN]))
      |=> sticky_q[B_OVERRUN]); // R5

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == A_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R6

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == A_MCLR) |=> ((mask_q & $past(bus_wdata)) == '0)); // R7

  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == A_MASK) |=> $stable(mask_q)); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0) && (sticky_q != '0)); // R9
endmodule

bind uart_irq_ctrl uart_irq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_overrun(ev_overrun),
  .ev_timeout(ev_timeout), .irq(irq), .status_vec(status_vec),
  .sticky_q(sticky_q), .mask_q(mask_q)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  rx_count, tx_count;
  logic        ev_overrun, ev_timeout;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [2:0] AD_MSET = 3'd0, AD_MCLR = 3'd1, AD_MASK = 3'd2,
                         AD_STICKY = 3'd3, AD_STAT = 3'd4, AD_RXT = 3'd5, AD_TXT = 3'd6;

  // {rx_count, tx_count, expected status}
  localparam int NV = 7;
  localparam logic [29:0] VEC [NV] = '{
    {7'd0,  7'd0,  16'h000A},
    {7'd32, 7'd0,  16'h0009},
    {7'd64, 7'd64, 16'h2015},
    {7'd31, 7'd33, 16'h2000},
    {7'd1,  7'd64, 16'h2010},
    {7'd63, 7'd32, 16'h2001},
    {7'd5,  7'd5,  16'h0000}
  };

  always #2 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_overrun(ev_overrun), .ev_timeout(ev_timeout), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {15'd0, irq}, {15'd0, exp});
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; rx_count = 7'd5; tx_count = 7'd5;
    ev_overrun = 1'b0; ev_timeout = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = AD_STAT; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(AD_MASK, d);   chk("R10 mask", d, 16'h0000);
    rd(AD_STICKY, d); chk("R10 sticky", d, 16'h0000);
    irq_chk("R10 irq", 1'b0);
    // R2 reset trigger levels
    rd(AD_RXT, d); chk("R2 rx trig reset", d, 16'd32);
    rd(AD_TXT, d); chk("R2 tx trig reset", d, 16'd32);

    // R1 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_count = VEC[i][29:23]; tx_count = VEC[i][22:16]; bus_addr = AD_STAT;
      #1 chk("R1 status", bus_rdata, VEC[i][15:0]);
    end

    // R5 clear all sticky bits
    wr(AD_STICKY, 16'hFFFF);
    rd(AD_STICKY, d); chk("R5 w1c clears", d, 16'h0000);

    // R3 tx trigger lands on bit10; rx empty lands on bit1
    @(negedge clk); tx_count = 7'd40; rx_count = 7'd0;
    @(negedge clk); tx_count = 7'd5;  rx_count = 7'd5;
    rd(AD_STICKY, d); chk("R3 status to sticky", d, 16'h0402);
    wr(AD_STICKY, 16'hFFFF);

    // R4 events
    @(negedge clk); ev_overrun = 1'b1;
    @(negedge clk); ev_overrun = 1'b0;
    rd(AD_STICKY, d); chk("R4 overrun bit5", d, 16'h0020);
    @(negedge clk); ev_timeout = 1'b1;
    @(negedge clk); ev_timeout = 1'b0;
    rd(AD_STICKY, d); chk("R4 timeout bit8", d, 16'h0120);
    wr(AD_STICKY, 16'h0120);

    // R5 set wins over simultaneous clear
    @(negedge clk);
    ev_overrun = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AD_STICKY; bus_wdata = 16'h0020;
    @(negedge clk);
    ev_overrun = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(AD_STICKY, d); chk("R5 set wins", d, 16'h0020);
    wr(AD_STICKY, 16'h0020);
    rd(AD_STICKY, d); chk("R5 cleared after", d, 16'h0000);

    // R6 / R7 / R8 mask
    wr(AD_MSET, 16'h0021);
    rd(AD_MASK, d); chk("R6 mask set", d, 16'h0021);
    wr(AD_MSET, 16'h0100);
    rd(AD_MASK, d); chk("R6 mask or", d, 16'h0121);
    wr(AD_MCLR, 16'h0001);
    rd(AD_MASK, d); chk("R7 mask clear", d, 16'h0120);
    wr(AD_MASK, 16'hFFFF);
    rd(AD_MASK, d); chk("R8 direct write ignored", d, 16'h0120);

    // R9 interrupt
    irq_chk("R9 idle low", 1'b0);
    @(negedge clk); ev_timeout = 1'b1;
    @(negedge clk); ev_timeout = 1'b0;
    #1 chk("R9 masked source high", {15'd0, irq}, 16'h0001);
    wr(AD_STICKY, 16'h0100);
    irq_chk("R9 low after clear", 1'b0);
    @(negedge clk); rx_count = 7'd40;
    @(negedge clk); rx_count = 7'd5;
    rd(AD_STICKY, d); chk("R9 unmasked sticky", d, 16'h0001);
    irq_chk("R9 unmasked source low", 1'b0);
    wr(AD_STICKY, 16'h0001);

    // R2 trigger writes
    wr(AD_RXT, 16'd8);
    rd(AD_RXT, d);  chk("R2 rx trig write", d, 16'd8);
    rd(AD_STAT, d); chk("R2 below new rx trig", d, 16'h0000);
    @(negedge clk); rx_count = 7'd8; bus_addr = AD_STAT;
    #1 chk("R2 at new rx trig", bus_rdata, 16'h0001);
    wr(AD_TXT, 16'd0);
    rd(AD_STAT, d); chk("R2 tx trig zero", d, 16'h2001);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule